// File: doc/BRIEF.md
# Integration Period Measurement Sequencer

This block paces a bank of current-input converters that each carry two switched integrators per channel. While one integrator collects charge, the other is digitised. The sequencer counts a programmed integration period on a 12.5 ns system clock. At the end of each period it flips the integrator-select line, so the two sides trade roles. On the same cycle it raises a one-cycle strobe that tells the downstream data packer a finished integration is ready to be read out.

Software sets the period as a minus-one tick count: a value N gives a period of N+1 clock cycles. The value is held inside a legal window, by default 13279 to 79999999, which is roughly 166 µs to 1 s. Three one-cycle commands control the sequencer:

- run: integrate back to back until stopped.
- once: run exactly one period, then go idle.
- halt: stop after the current period.

The active period is always allowed to complete. A period count change takes effect only when the next period begins.

Top module: `integ_seq`

## Requirements
- R1: After reset `busy`, `conv_sel` and `rd_strobe` are all 0.
- R2: A period lasts (N+1) clock cycles for a latched count N. The first strobe comes N+1 cycles after the edge that accepted the start command, and later strobes in continuous mode are N+1 cycles apart.
- R3: A count below MIN_CNT is used as MIN_CNT, and a count above MAX_CNT is used as MAX_CNT.
- R4: `rd_strobe` is a one-cycle pulse, and `conv_sel` changes value on exactly the cycles where `rd_strobe` is 1.
- R5: With `cmd_run` the sequencer stays busy and starts a new period immediately after each one ends, until a halt.
- R6: With `cmd_once` the sequencer runs one period, strobes once, and then `busy` returns to 0.
- R7: `period_cnt` is sampled only when a period begins, whether that is a start from idle or a back-to-back restart. A change in the middle of a period does not alter that period.
- R8: A halt during a period lets that period finish and strobe, and then `busy` drops. A halt while idle has no effect.
- R9: A start command (`cmd_run` or `cmd_once`) that arrives while busy is ignored.
- R10: If `cmd_run` and `cmd_once` are both asserted while idle, continuous mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12.5 ns tick) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_run | input | 1 | One-cycle command to start continuous integration |
| cmd_once | input | 1 | One-cycle command to start a single integration |
| cmd_halt | input | 1 | One-cycle command to stop after the current period |
| period_cnt | input | CNT_W | Period length minus one, in clock ticks |
| busy | output | 1 | High while an integration period is in progress |
| conv_sel | output | 1 | Integrator-side select; flips at each period end |
| rd_strobe | output | 1 | One-cycle readout-start pulse at each period end |

## Verification
The bench builds the block with CNT_W=10, MIN_CNT=4 and MAX_CNT=40. With these values, periods last a handful of cycles, and both clamp limits can be driven directly: a count of 1 falls below the window and a count of 500 falls above it. Because periods are short, the bench can place commands at chosen points inside a period: mid-period count changes, halts and repeated starts, and a halt that lands on the final cycle. A behavioural model predicts `busy`, `conv_sel` and `rd_strobe` on every cycle, and the bench compares all three against the design.

// File: rtl/integ_seq_pkg.sv
// Shared types for the integration sequencer.
// Assumes nothing beyond a two-bit state encoding.
package integ_seq_pkg;

    // Operating mode of the sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOOP = 2'd1,
        SEQ_ONCE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/integ_period_timer.sv
// Counts one integration period of (limit+1) ticks.
// The limit is the clamped count, latched whenever load is high.
// Assumes load is never asserted together with a period end unless a
// restart is intended, and that MIN_CNT <= MAX_CNT < 2**CNT_W.
module integ_period_timer #(
    parameter int CNT_W   = 28,
    parameter int MIN_CNT = 13279,
    parameter int MAX_CNT = 79999999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic [CNT_W-1:0] period_cnt,
    output logic             period_end
);

    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_CNT);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MAX_CNT);

    logic [CNT_W-1:0] tick_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] clamped;

    // Keep the requested count inside the legal window.
    always_comb begin
        if (period_cnt < LO_LIM)
            clamped = LO_LIM;
        else if (period_cnt > HI_LIM)
            clamped = HI_LIM;
        else
            clamped = period_cnt;
    end

    // Restart or advance the tick counter; latch the limit at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q  <= '0;
            limit_q <= LO_LIM;
        end else if (load) begin
            tick_q  <= '0;
            limit_q <= clamped;
        end else if (active) begin
            tick_q  <= tick_q + 1'b1;
        end
    end

    // Flag the last tick of the running period.
    assign period_end = active && (tick_q == limit_q);

endmodule

// File: rtl/integ_mode_ctrl.sv
// Mode state machine: idle, continuous, single/draining.
// A halt in continuous mode turns the active period into a final one.
// Start commands are honoured only while idle; run wins over once.
module integ_mode_ctrl
    import integ_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_run,
    input  logic cmd_once,
    input  logic cmd_halt,
    input  logic period_end,
    output logic active,
    output logic launch,
    output logic reload
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Accept a start only from idle; restart back to back unless halted.
    assign launch = (state_q == SEQ_IDLE) && (cmd_run || cmd_once);
    assign reload = (state_q == SEQ_LOOP) && period_end && !cmd_halt;
    assign active = (state_q != SEQ_IDLE);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cmd_run)       state_d = SEQ_LOOP;
                else if (cmd_once) state_d = SEQ_ONCE;
            end
            SEQ_LOOP: begin
                if (cmd_halt)
                    state_d = period_end ? SEQ_IDLE : SEQ_ONCE;
            end
            SEQ_ONCE: begin
                if (period_end) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/integ_side_sel.sv
// Integrator-side select and readout strobe.
// Both are registered from the same period-end flag, so they change on
// the same cycle.
module integ_side_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic period_end,
    output logic conv_sel,
    output logic rd_strobe
);

    // Swap integrator sides and pulse the readout strobe at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_sel  <= 1'b0;
            rd_strobe <= 1'b0;
        end else begin
            rd_strobe <= period_end;
            if (period_end) conv_sel <= ~conv_sel;
        end
    end

endmodule

// File: rtl/integ_seq.sv
// Integration period sequencer top.
// Joins the mode controller, the period timer and the side selector.
// Assumes one-cycle command pulses and MIN_CNT >= 1, so that strobes
// never fall on adjacent cycles.
module integ_seq #(
    parameter int CNT_W   = 28,
    parameter int MIN_CNT = 13279,
    parameter int MAX_CNT = 79999999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_run,
    input  logic             cmd_once,
    input  logic             cmd_halt,
    input  logic [CNT_W-1:0] period_cnt,
    output logic             busy,
    output logic             conv_sel,
    output logic             rd_strobe
);

    logic active;
    logic launch;
    logic reload;
    logic period_end;
    logic load;

    // A new period starts either from idle or back to back.
    assign load = launch || reload;
    assign busy = active;

    integ_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_run    (cmd_run),
        .cmd_once   (cmd_once),
        .cmd_halt   (cmd_halt),
        .period_end (period_end),
        .active     (active),
        .launch     (launch),
        .reload     (reload)
    );

    integ_period_timer #(
        .CNT_W   (CNT_W),
        .MIN_CNT (MIN_CNT),
        .MAX_CNT (MAX_CNT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .active     (active),
        .period_cnt (period_cnt),
        .period_end (period_end)
    );

    integ_side_sel u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .conv_sel   (conv_sel),
        .rd_strobe  (rd_strobe)
    );

endmodule

// File: rtl/integ_seq_chk.sv
// Port-level protocol checks for the integration sequencer.
// Attached to every integ_seq instance through bind.
module integ_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_run,
    input logic cmd_once,
    input logic busy,
    input logic conv_sel,
    input logic rd_strobe
);

    // Strobe implies the select changed on that same cycle.
    assert_strobe_flips_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (conv_sel != $past(conv_sel)));

    // Select never changes without a strobe.
    assert_sel_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_sel != $past(conv_sel)) |-> rd_strobe);

    // Strobe lasts a single cycle.
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // Leaving busy always coincides with a completed period.
    assert_finish_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rd_strobe);

    // Idle stays idle unless a start command arrives.
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_run && !cmd_once) |=> !busy);

    // No readout strobe directly after an idle cycle.
    assert_no_idle_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !rd_strobe);

endmodule

bind integ_seq integ_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_run   (cmd_run),
    .cmd_once  (cmd_once),
    .busy      (busy),
    .conv_sel  (conv_sel),
    .rd_strobe (rd_strobe)
);

// File: tb/sim_integ_seq.sv
module sim_integ_seq;

    localparam int CW   = 10;
    localparam int LO   = 4;
    localparam int HI   = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_run = 1'b0;
    logic          cmd_once = 1'b0;
    logic          cmd_halt = 1'b0;
    logic [CW-1:0] period_cnt = CW'(10);
    logic          busy;
    logic          conv_sel;
    logic          rd_strobe;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    compare_on = 1'b0;
    bit    finished = 1'b0;

    // Reference model state.
    int m_busy = 0, m_cont = 0, m_cnt = 0, m_lim = 0, m_sel = 0, m_str = 0;

    always #5 clk = ~clk;

    integ_seq #(.CNT_W(CW), .MIN_CNT(LO), .MAX_CNT(HI)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_run(cmd_run), .cmd_once(cmd_once),
        .cmd_halt(cmd_halt), .period_cnt(period_cnt),
        .busy(busy), .conv_sel(conv_sel), .rd_strobe(rd_strobe)
    );

    function automatic int clampv(int p);
        if (p < LO) return LO;
        if (p > HI) return HI;
        return p;
    endfunction

    // Behavioural expectation, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cont = 0; m_cnt = 0; m_lim = 0; m_sel = 0; m_str = 0;
        end else begin
            m_str = 0;
            if (m_busy == 0) begin
                if (cmd_run || cmd_once) begin
                    m_busy = 1; m_cont = cmd_run ? 1 : 0;
                    m_cnt = 0; m_lim = clampv(int'(period_cnt));
                end
            end else begin
                if (cmd_halt) m_cont = 0;
                if (m_cnt == m_lim) begin
                    m_str = 1; m_sel = 1 - m_sel;
                    if (m_cont != 0) begin
                        m_cnt = 0; m_lim = clampv(int'(period_cnt));
                    end else m_busy = 0;
                end else m_cnt++;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            chk("busy", int'(busy), m_busy);
            chk("conv_sel R4", int'(conv_sel), m_sel);
            chk("rd_strobe R4", int'(rd_strobe), m_str);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(bit r, bit o, bit h);
        @(negedge clk);
        cmd_run = r; cmd_once = o; cmd_halt = h;
        @(negedge clk);
        cmd_run = 1'b0; cmd_once = 1'b0; cmd_halt = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk("reset busy R1", int'(busy), 0);
        chk("reset sel R1", int'(conv_sel), 0);
        chk("reset strobe R1", int'(rd_strobe), 0);
        compare_on = 1'b1;

        tag = "R2 R6";                       // single, in-range count
        period_cnt = CW'(10);
        pulse(0, 1, 0); idle(20);

        tag = "R3";                          // below and above the window
        period_cnt = CW'(1);
        pulse(0, 1, 0); idle(12);
        period_cnt = CW'(500);
        pulse(0, 1, 0); idle(50);

        tag = "R5";                          // continuous, back to back
        period_cnt = CW'(6);
        pulse(1, 0, 0); idle(30);

        tag = "R9";                          // starts while running
        pulse(0, 1, 0); idle(2); pulse(1, 0, 0); idle(10);

        tag = "R7";                          // count change mid-period
        idle(3); period_cnt = CW'(12); idle(40);

        tag = "R8";                          // halt mid-period, then idle halt
        pulse(0, 0, 1); idle(20);
        pulse(0, 0, 1); idle(5);

        tag = "R6 R9";                       // single, with late run ignored
        period_cnt = CW'(8);
        pulse(0, 1, 0); idle(3); pulse(1, 0, 0); idle(15);

        tag = "R10";                         // both starts together
        period_cnt = CW'(5);
        pulse(1, 1, 0); idle(25);

        tag = "R8";                          // halt on a period's last cycle
        while (!rd_strobe) @(negedge clk);
        idle(4);                             // tick 4 of a 6-cycle period
        @(negedge clk); cmd_halt = 1'b1;     // tick 5 = last cycle
        @(negedge clk); cmd_halt = 1'b0;
        idle(15);

        compare_on = 1'b0;
        finish_run();
    end

endmodule